// File: doc/BRIEF.md
# Interleaved Two-Bank Video Memory Address Mapper

This block turns a linear, byte-addressed transfer over a 64-bit view of video memory into a series of single-word accesses on two 32-bit banks. Consecutive 32-bit words of the linear view alternate between the banks. Address bit 2 picks the bank for each word, and address bits 22:3 give the word index inside that bank. A transfer may start and end on any byte. Partial words at either end are handled with byte enables, and every word in between is written or read whole.

A requester presents a byte address, a byte length and a direction. Upper address bits beyond the 8 MB window are dropped. A transfer that would run past the top of the window is shortened so that it ends exactly at the limit. While the transfer runs, the block makes one bank access per cycle. It shows the linear word index of the current access on `xfer_word`, so that the requester can drive the lane-aligned write word on `wr_data`. For reads, the block returns each bank word one cycle after the access, with the enabled lanes marked.

Top module: `vmap_interleave_mapper`

## Requirements
- R1: Only address bits 22:0 are used. Bits 31:23 of the request address have no effect on where data lands.
- R2: When start + length exceeds 0x800000, the transfer is shortened to 0x800000 − start bytes.
- R3: A byte at window address A is accessed on bank A[2], at bank word index A[22:3], in byte lane A[1:0]. Lane i is bits 8i+7:8i of the data and is enabled by bit i of the byte enable.
- R4: Successive accesses of one transfer step the linear word index (`xfer_word` = A[22:2]) up by one. They therefore alternate between the banks, with exactly one bank enabled in any access cycle.
- R5: When the start is not word aligned, the first access enables lanes start[1:0] up to 3. If the transfer ends inside that word, the first access stops at the last byte instead.
- R6: When a transfer ends mid-word after two or more accesses, the final access enables lanes 0 up to (end address)[1:0] only.
- R7: A transfer lying inside one word makes a single access whose enables cover exactly its bytes.
- R8: Every access other than a partial first or last word enables all four lanes (4'b1111).
- R9: On writes, the enabled bank's write strobe is high and its write data equals `wr_data`. `wr_data` must hold the linear word given by `xfer_word`. Lanes outside the transfer are left unchanged.
- R10: On reads, `rd_valid` pulses one cycle after each access. `rd_be` repeats that access's enables, and `rd_data` carries the bank word with the disabled lanes forced to zero.
- R11: `busy` is high from the cycle after a request is accepted through the last access cycle. `done` is a one-cycle pulse in the following cycle. Requests presented while busy are ignored.
- R12: A request whose length is zero, after shortening, makes no bank access and pulses `done` in the cycle after acceptance.
- R13: After reset, `busy`, `done`, `rd_valid` and both bank enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; accepted when not busy |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| req_addr | input | 32 | Start byte address (upper bits ignored) |
| req_len | input | LW (24) | Transfer length in bytes |
| wr_data | input | 32 | Lane-aligned write word for `xfer_word` |
| xfer_word | output | AW-2 (21) | Linear word index of the current access |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rd_valid | output | 1 | Read word returned |
| rd_data | output | 32 | Returned read word, disabled lanes zero |
| rd_be | output | 4 | Lanes valid in `rd_data` |
| b0_en | output | 1 | Bank 0 access strobe |
| b0_we | output | 1 | Bank 0 write strobe |
| b0_addr | output | AW-3 (20) | Bank 0 word index |
| b0_be | output | 4 | Bank 0 byte enables |
| b0_wdata | output | 32 | Bank 0 write data |
| b0_rdata | input | 32 | Bank 0 read data, one cycle after access |
| b1_en | output | 1 | Bank 1 access strobe |
| b1_we | output | 1 | Bank 1 write strobe |
| b1_addr | output | AW-3 (20) | Bank 1 word index |
| b1_be | output | 4 | Bank 1 byte enables |
| b1_wdata | output | 32 | Bank 1 write data |
| b1_rdata | input | 32 | Bank 1 read data, one cycle after access |

## Verification
The bench aims at starts on each byte lane, transfers that fit inside one word, zero-length requests, addresses with the upper bits set, and transfers that run past the top of the window.

- A mapper that forgot to advance the pointer after a partial leading word would put the next pair of words over the same bank word, and the memory comparison would show it.
- A swapped bank or index would land bytes in the wrong bank word.
- A missing clip would make extra accesses beyond the window.
- A wrong enable would clobber neighbouring bytes, and those bytes are checked for being left untouched.

Requests held active during a busy transfer test that a second transfer is not started.

// File: rtl/vmap_pkg.sv
package vmap_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned DATA_W = 8 * LANES;
  localparam int unsigned NBANK  = 2;
  typedef logic [LANES-1:0] lane_mask_t;
endpackage

// File: rtl/vmap_reset_sync.sv
module vmap_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/vmap_window_clip.sv
// Drops address bits above the window and shortens a length that would
// run past the top of the window.
module vmap_window_clip #(
  parameter int unsigned AW = 23,
  parameter int unsigned LW = 24
) (
  input  logic [31:0]   in_addr,
  input  logic [LW-1:0] in_len,
  output logic [AW-1:0] base,
  output logic [LW-1:0] len_out
);
  localparam logic [LW:0] SPAN = (LW+1)'(1) << AW;

  logic [LW:0] space;
  logic [LW:0] len_x;
  logic        unused_hi;

  assign unused_hi = ^in_addr[31:AW];
  assign base      = in_addr[AW-1:0];

  always_comb begin
    space = SPAN - (LW+1)'(base);
    len_x = {1'b0, in_len};
    if (len_x > space) len_out = space[LW-1:0];
    else               len_out = in_len;
  end
endmodule

// File: rtl/vmap_lane_gen.sv
// Byte count and lane enables for the word holding the current address.
module vmap_lane_gen
  import vmap_pkg::*;
#(
  parameter int unsigned LW = 24
) (
  input  logic [1:0]    off,
  input  logic [LW-1:0] rem,
  output lane_mask_t    be,
  output logic [2:0]    nbytes
);
  logic [2:0] room;
  logic [2:0] off3;
  logic [2:0] stop;

  always_comb begin
    off3 = {1'b0, off};
    room = 3'd4 - off3;
    if (rem < LW'(room)) nbytes = rem[2:0];
    else                 nbytes = room;
    stop = off3 + nbytes;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be[i] = (3'(i) >= off3) && (3'(i) < stop);
  end
endmodule

// File: rtl/vmap_bank_route.sv
// Steers one access to the selected bank and merges returned read data.
module vmap_bank_route
  import vmap_pkg::*;
#(
  parameter int unsigned IW = 20
) (
  input  logic                         act,
  input  logic                         we,
  input  logic                         bank_sel,
  input  logic [IW-1:0]                idx,
  input  lane_mask_t                   be,
  input  logic [DATA_W-1:0]            wdata,
  output logic [NBANK-1:0]             en_o,
  output logic [NBANK-1:0]             we_o,
  output logic [NBANK-1:0][IW-1:0]     addr_o,
  output logic [NBANK-1:0][LANES-1:0]  be_o,
  output logic [NBANK-1:0][DATA_W-1:0] wdata_o,
  input  logic [NBANK-1:0][DATA_W-1:0] rdata,
  input  logic                         rd_sel,
  input  lane_mask_t                   rd_mask,
  output logic [DATA_W-1:0]            rd_data
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit        = act && (bank_sel == 1'(b));
    assign en_o[b]    = hit;
    assign we_o[b]    = hit && we;
    assign addr_o[b]  = idx;
    assign be_o[b]    = hit ? be : '0;
    assign wdata_o[b] = wdata;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_rlane
    assign rd_data[8*i +: 8] = rd_mask[i] ? rdata[rd_sel][8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/vmap_interleave_mapper.sv
module vmap_interleave_mapper
  import vmap_pkg::*;
#(
  parameter int unsigned AW = 23,
  parameter int unsigned LW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [31:0]       req_addr,
  input  logic [LW-1:0]     req_len,
  input  logic [31:0]       wr_data,
  output logic [AW-3:0]     xfer_word,
  output logic              busy,
  output logic              done,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic [3:0]        rd_be,
  output logic              b0_en,
  output logic              b0_we,
  output logic [AW-4:0]     b0_addr,
  output logic [3:0]        b0_be,
  output logic [31:0]       b0_wdata,
  input  logic [31:0]       b0_rdata,
  output logic              b1_en,
  output logic              b1_we,
  output logic [AW-4:0]     b1_addr,
  output logic [3:0]        b1_be,
  output logic [31:0]       b1_wdata,
  input  logic [31:0]       b1_rdata
);
  localparam int unsigned IW = AW - 3;

  logic rst_sync_n;

  // state registers
  logic          busy_q, busy_d;
  logic          wr_q, wr_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] rem_q, rem_d;
  logic          done_q, done_d;
  logic          rdv_q, rdv_d;
  logic          rdsel_q, rdsel_d;
  lane_mask_t    rdbe_q, rdbe_d;

  logic          st_en;
  logic          rd_en;
  logic [AW-1:0] clip_base;
  logic [LW-1:0] clip_len;
  lane_mask_t    cur_be;
  logic [2:0]    cur_nb;
  logic [LW-1:0] rem_after;

  logic [NBANK-1:0]             bk_en, bk_we;
  logic [NBANK-1:0][IW-1:0]     bk_addr;
  logic [NBANK-1:0][LANES-1:0]  bk_be;
  logic [NBANK-1:0][DATA_W-1:0] bk_wdata;
  logic [NBANK-1:0][DATA_W-1:0] bk_rdata;

  vmap_reset_sync i_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  vmap_window_clip #(.AW(AW), .LW(LW)) i_clip (
    .in_addr (req_addr),
    .in_len  (req_len),
    .base    (clip_base),
    .len_out (clip_len)
  );

  vmap_lane_gen #(.LW(LW)) i_lanes (
    .off    (addr_q[1:0]),
    .rem    (rem_q),
    .be     (cur_be),
    .nbytes (cur_nb)
  );

  assign bk_rdata[0] = b0_rdata;
  assign bk_rdata[1] = b1_rdata;

  vmap_bank_route #(.IW(IW)) i_route (
    .act      (busy_q),
    .we       (wr_q),
    .bank_sel (addr_q[2]),
    .idx      (addr_q[AW-1:3]),
    .be       (cur_be),
    .wdata    (wr_data),
    .en_o     (bk_en),
    .we_o     (bk_we),
    .addr_o   (bk_addr),
    .be_o     (bk_be),
    .wdata_o  (bk_wdata),
    .rdata    (bk_rdata),
    .rd_sel   (rdsel_q),
    .rd_mask  (rdbe_q),
    .rd_data  (rd_data)
  );

  // next state
  always_comb begin
    busy_d    = busy_q;
    wr_d      = wr_q;
    addr_d    = addr_q;
    rem_d     = rem_q;
    done_d    = 1'b0;
    rem_after = rem_q - LW'(cur_nb);
    if (busy_q) begin
      addr_d = addr_q + AW'(cur_nb);
      rem_d  = rem_after;
      if (rem_after == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end else if (req_valid) begin
      addr_d = clip_base;
      rem_d  = clip_len;
      wr_d   = req_write;
      if (clip_len == '0) done_d = 1'b1;
      else                busy_d = 1'b1;
    end
    rdv_d   = busy_q && !wr_q;
    rdsel_d = addr_q[2];
    rdbe_d  = cur_be;
  end

  assign st_en = busy_q | req_valid;
  assign rd_en = busy_q;

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      busy_q  <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      rem_q   <= '0;
      done_q  <= 1'b0;
      rdv_q   <= 1'b0;
      rdsel_q <= 1'b0;
      rdbe_q  <= '0;
    end else begin
      if (st_en) begin
        busy_q <= busy_d;
        wr_q   <= wr_d;
        addr_q <= addr_d;
        rem_q  <= rem_d;
      end
      if (rd_en) begin
        rdsel_q <= rdsel_d;
        rdbe_q  <= rdbe_d;
      end
      done_q <= done_d;
      rdv_q  <= rdv_d;
    end
  end

  assign xfer_word = addr_q[AW-1:2];
  assign busy      = busy_q;
  assign done      = done_q;
  assign rd_valid  = rdv_q;
  assign rd_be     = rdbe_q;

  assign b0_en    = bk_en[0];
  assign b0_we    = bk_we[0];
  assign b0_addr  = bk_addr[0];
  assign b0_be    = bk_be[0];
  assign b0_wdata = bk_wdata[0];
  assign b1_en    = bk_en[1];
  assign b1_we    = bk_we[1];
  assign b1_addr  = bk_addr[1];
  assign b1_be    = bk_be[1];
  assign b1_wdata = bk_wdata[1];
endmodule

// File: rtl/vmap_checker.sv
module vmap_checker #(
  parameter int unsigned AW = 23
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          rd_valid,
  input logic [AW-3:0] xfer_word,
  input logic [31:0]   wr_data,
  input logic          b0_en,
  input logic          b0_we,
  input logic [AW-4:0] b0_addr,
  input logic [3:0]    b0_be,
  input logic [31:0]   b0_wdata,
  input logic          b1_en,
  input logic          b1_we,
  input logic [AW-4:0] b1_addr,
  input logic [3:0]    b1_be,
  input logic [31:0]   b1_wdata
);
  localparam int unsigned WW = AW - 2;

  p_one_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(b0_en && b1_en));

  p_step_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (xfer_word == $past(xfer_word) + WW'(1)));

  p_bank0_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
    b0_en |-> (!xfer_word[0] && b0_addr == xfer_word[WW-1:1]));

  p_bank1_odd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    b1_en |-> (xfer_word[0] && b1_addr == xfer_word[WW-1:1]));

  p_enables_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (b0_en || b1_en) |-> ($countones(b0_be | b1_be) > 0));

  p_wdata_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((b0_en && b0_we) || (b1_en && b1_we)) |->
      (b0_en ? b0_wdata == wr_data : b1_wdata == wr_data));

  p_access_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (b0_en || b1_en) |-> busy);

  p_done_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_read_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(b0_en || b1_en));
endmodule

bind vmap_interleave_mapper vmap_checker #(.AW(AW)) i_vmap_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .busy      (busy),
  .done      (done),
  .rd_valid  (rd_valid),
  .xfer_word (xfer_word),
  .wr_data   (wr_data),
  .b0_en     (b0_en),
  .b0_we     (b0_we),
  .b0_addr   (b0_addr),
  .b0_be     (b0_be),
  .b0_wdata  (b0_wdata),
  .b1_en     (b1_en),
  .b1_we     (b1_we),
  .b1_addr   (b1_addr),
  .b1_be     (b1_be),
  .b1_wdata  (b1_wdata)
);

// File: tb/test_vmap_interleave_mapper.sv
module test_vmap_interleave_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 23;
  localparam int LW = 24;
  localparam int unsigned WIN = 32'h0080_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_addr;
  logic [LW-1:0] req_len;
  logic [31:0] wr_data;
  logic [AW-3:0] xfer_word;
  logic        busy, done, rd_valid;
  logic [31:0] rd_data;
  logic [3:0]  rd_be;
  logic        b0_en, b0_we, b1_en, b1_we;
  logic [AW-4:0] b0_addr, b1_addr;
  logic [3:0]  b0_be, b1_be;
  logic [31:0] b0_wdata, b1_wdata, b0_rdata, b1_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] pat = 8'h00;

  logic [7:0] vmem [int unsigned];
  logic [7:0] refm [int unsigned];

  always #(CLK_PERIOD/2) clk = ~clk;

  vmap_interleave_mapper i_vmap_interleave_mapper (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .wr_data(wr_data),
    .xfer_word(xfer_word), .busy(busy), .done(done), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_be(rd_be),
    .b0_en(b0_en), .b0_we(b0_we), .b0_addr(b0_addr), .b0_be(b0_be),
    .b0_wdata(b0_wdata), .b0_rdata(b0_rdata),
    .b1_en(b1_en), .b1_we(b1_we), .b1_addr(b1_addr), .b1_be(b1_be),
    .b1_wdata(b1_wdata), .b1_rdata(b1_rdata)
  );

  // R3 placement: bank A[2], index A[22:3], lane A[1:0]
  function automatic int unsigned key_bank(bit b, logic [19:0] idx, logic [1:0] ln);
    return 32'({b, idx, ln});
  endfunction
  function automatic int unsigned key_of(int unsigned a);
    logic [22:0] x = a[22:0];
    return key_bank(x[2], x[22:3], x[1:0]);
  endfunction
  function automatic logic [7:0] src_byte(int unsigned a, logic [7:0] p);
    return a[7:0] ^ a[15:8] ^ {1'b0, a[22:16]} ^ p ^ 8'h5A;
  endfunction
  function automatic logic [7:0] vget(int unsigned k);
    return vmem.exists(k) ? vmem[k] : 8'h00;
  endfunction
  function automatic logic [7:0] rget(int unsigned k);
    return refm.exists(k) ? refm[k] : 8'h00;
  endfunction
  function automatic logic [3:0] mk_be(int lo, int hi);
    logic [3:0] m = '0;
    for (int i = 0; i < 4; i++) if (i >= lo && i <= hi) m[i] = 1'b1;
    return m;
  endfunction

  always_comb begin
    for (int i = 0; i < 4; i++)
      wr_data[8*i +: 8] = src_byte({11'd0, xfer_word, 2'(i)}, pat);
  end

  // behavioural banks, one-cycle read latency
  always @(posedge clk) begin
    if (b0_en) begin
      if (b0_we) begin
        for (int i = 0; i < 4; i++) if (b0_be[i]) vmem[key_bank(1'b0, b0_addr, 2'(i))] = b0_wdata[8*i +: 8];
      end else
        b0_rdata <= {vget(key_bank(1'b0,b0_addr,2'd3)), vget(key_bank(1'b0,b0_addr,2'd2)),
                     vget(key_bank(1'b0,b0_addr,2'd1)), vget(key_bank(1'b0,b0_addr,2'd0))};
    end
    if (b1_en) begin
      if (b1_we) begin
        for (int i = 0; i < 4; i++) if (b1_be[i]) vmem[key_bank(1'b1, b1_addr, 2'(i))] = b1_wdata[8*i +: 8];
      end else
        b1_rdata <= {vget(key_bank(1'b1,b1_addr,2'd3)), vget(key_bank(1'b1,b1_addr,2'd2)),
                     vget(key_bank(1'b1,b1_addr,2'd1)), vget(key_bank(1'b1,b1_addr,2'd0))};
    end
  end

  // access monitor
  int acc_cnt, rd_seen, rd_bad;
  logic [3:0] first_be, last_be, prev_be;
  int unsigned prev_word;
  always @(negedge clk) begin
    if (rd_valid) begin
      rd_seen++;
      if (rd_be != prev_be) rd_bad++;
      for (int i = 0; i < 4; i++) begin
        if (rd_be[i]) begin
          if (rd_data[8*i +: 8] != rget(key_of(prev_word*4 + i))) rd_bad++;
        end else if (rd_data[8*i +: 8] != 8'h00) rd_bad++;
      end
    end
    if (b0_en || b1_en) begin
      acc_cnt++;
      if (acc_cnt == 1) first_be = b0_en ? b0_be : b1_be;
      last_be   = b0_en ? b0_be : b1_be;
      prev_be   = last_be;
      prev_word = 32'(xfer_word);
    end
  end

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic mem_cmp(int unsigned lo, int unsigned hi, string what);
    int bad = 0;
    int unsigned first_a = 0;
    for (int unsigned a = lo; a < hi; a++)
      if (vget(key_of(a)) != rget(key_of(a))) begin
        if (bad == 0) first_a = a;
        bad++;
      end
    chk(bad == 0, what, bad, 0);
    if (bad != 0) $display("  first mismatch at %h", first_a);
  endtask

  task automatic do_xfer(input logic [31:0] addr, input int len, input bit wr,
                         input bit poke, input string tag);
    int unsigned base = addr & 32'h007F_FFFF;
    int unsigned n = (len > int'(WIN - base)) ? WIN - base : len;
    int unsigned words = (n == 0) ? 0 : ((base + n - 1) >> 2) - (base >> 2) + 1;
    int off = base & 3;
    int lastlane = (off + int'(n) > 4) ? 3 : off + int'(n) - 1;
    logic [3:0] exp_first = mk_be(off, lastlane);
    logic [3:0] exp_last  = (words >= 2) ? mk_be(0, (base + n - 1) & 3) : exp_first;
    int unsigned junk = base ^ 32'h0040_0000;
    int tbad = 0;
    @(negedge clk);
    pat = 8'($urandom);
    if (wr) for (int unsigned a = base; a < base + n; a++) refm[key_of(a)] = src_byte(a, pat);
    acc_cnt = 0; rd_seen = 0; rd_bad = 0; first_be = '0; last_be = '0;
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_len = LW'(len);
    for (int c = 1; c <= int'(words) + 1; c++) begin
      @(negedge clk);
      req_valid = poke && (c < int'(words));
      req_addr  = junk;
      req_write = 1'b1;
      if (c <= int'(words)) begin
        if (!(busy && !done)) tbad++;
      end else if (!(done && !busy)) tbad++;
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(tbad == 0, {tag, " R11 busy/done timing"}, tbad, 0);
    if (n == 0) chk(acc_cnt == 0, {tag, " R12 zero length makes no access"}, acc_cnt, 0);
    else begin
      chk(acc_cnt == int'(words), {tag, " R4 R2 access count"}, acc_cnt, words);
      chk(first_be == exp_first, {tag, " R5 R7 first enables"}, first_be, exp_first);
      chk(last_be == exp_last, {tag, " R6 R8 last enables"}, last_be, exp_last);
    end
    if (wr) mem_cmp((base >= 4) ? base - 4 : 0, (base + n + 4 > WIN) ? WIN : base + n + 4,
                    {tag, " R9 R3 write placement and untouched neighbours"});
    else chk(rd_seen == int'(words) && rd_bad == 0, {tag, " R10 read return"}, rd_bad, 0);
    if (poke) mem_cmp(junk, junk + 32, {tag, " R11 request while busy ignored"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(!busy && !done && !rd_valid && !b0_en && !b1_en, "R13 reset state",
        {busy, done, rd_valid, b0_en, b1_en}, 0);

    do_xfer(32'h0000_0100, 16, 1'b1, 1'b0, "aligned R8");
    do_xfer(32'h0000_0203, 9,  1'b1, 1'b0, "unaligned R5 R6");
    do_xfer(32'h0000_0301, 2,  1'b1, 1'b0, "one-word R7");
    do_xfer(32'h0000_0040, 0,  1'b1, 1'b0, "zero R12");
    do_xfer(32'hC000_1235, 9,  1'b1, 1'b0, "upper bits R1");
    do_xfer(32'h007F_FFFA, 20, 1'b1, 1'b0, "window end R2");
    do_xfer(32'h0000_0500, 24, 1'b1, 1'b1, "busy poke R11");
    do_xfer(32'h0000_01FE, 24, 1'b0, 1'b0, "read R10");
    do_xfer(32'h0000_0200, 16, 1'b0, 1'b0, "read R10");
    do_xfer(32'hFF80_1235, 9,  1'b0, 1'b0, "read R1");
    do_xfer(32'h007F_FFF9, 50, 1'b0, 1'b0, "read R2");
    do_xfer(32'h007F_FFFF, 1,  1'b1, 1'b0, "last byte R2");

    for (int t = 0; t < 80; t++) begin
      logic [31:0] a = 32'h1000 + $urandom_range(0, 255);
      if ($urandom_range(0, 3) == 0) a = a | ($urandom & 32'hFF80_0000);
      do_xfer(a, $urandom_range(0, 40), 1'($urandom_range(0, 1)), 1'b0, "random");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule